// File: doc/BRIEF.md
# Serial Flash Controller Register and Interrupt Front End

This block is the software-visible face of a serial flash controller. It sits on a simple 32-bit memory-mapped bus with a select, a write flag, a byte address and write data, and returns read data in the same cycle. Behind it, a separate transfer engine does the actual serial shifting. The block holds the configuration words that the engine consumes: a clock setting, a device setting, a command word and a data word. It also passes each accepted command write to the engine as a single-cycle start strobe.

Interrupt handling is split into an enable mask and a pending set. The mask can only be changed through two addresses, one that sets bits and one that clears them. Software can see the pending events either unmasked or masked by the enables, and acknowledges them by writing ones to the masked view. The engine reports each finished word with a one-cycle pulse. The block turns this into a sticky pending bit and drives one level-sensitive interrupt line.

Top module: `flash_ctl_regs`

## Requirements
- R1: After a synchronous active-low reset every register reads zero, `irq` is low and `cmd_start` is low.
- R2: The clock word at byte offset 0x40 keeps bit 31 (clock enable) and bits 15:0 (divider). Its other bits read zero. The device word at 0x44 and the data word at 0x50 keep all 32 bits. The stored values drive `clk_cfg`, `dev_cfg` and `tx_data`.
- R3: Writing a 1 in bit 1 at 0x28 sets the word-complete enable, and writing a 1 in bit 1 at 0x2C clears it. A 0 in bit 1 leaves the enable unchanged. Both addresses read the enable mask with only bit 1 live.
- R4: An `eng_word_done` pulse makes the word-complete event pending. It stays pending until it is acknowledged. The pending event reads as bit 1 at 0x20 and as bit 1 of the status word at 0x4C. Bit 0 of the status word shows `eng_busy`.
- R5: Writing a 1 in bit 1 at 0x24 clears the pending event. A 0 in bit 1 there, or any write to 0x20, leaves it pending.
- R6: If an `eng_word_done` pulse arrives in the same cycle as an acknowledge, the event remains pending.
- R7: Offset 0x24 reads the pending bits ANDed with the enable mask, and `irq` is high exactly when any of those masked bits is set.
- R8: A write to 0x48 while `eng_busy` is low stores the word on `cmd_word` and raises `cmd_start` for exactly the one cycle after the write edge. Reading 0x48 returns the stored word.
- R9: A write to 0x48 while `eng_busy` is high changes neither `cmd_word` nor `cmd_start`.
- R10: Any other word offset, and any address whose two low bits are not zero, reads zero, and writing to it changes no register.
- R11: An `eng_rx_load` pulse loads `eng_rx_data` into the data word. If it coincides with a bus write to 0x50, the engine value is the one kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle, zero when not reading |
| eng_busy | input | 1 | Engine is running an operation |
| eng_word_done | input | 1 | One-cycle pulse per finished word |
| eng_rx_load | input | 1 | Load received word into the data register |
| eng_rx_data | input | 32 | Received word |
| clk_cfg | output | 32 | Stored clock word |
| dev_cfg | output | 32 | Stored device word |
| cmd_word | output | 32 | Last accepted command word |
| cmd_start | output | 1 | One-cycle start strobe |
| tx_data | output | 32 | Stored data word |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that `eng_word_done` and `eng_rx_load` are single-cycle pulses. They also assume that only one bus access happens per cycle, so a set and a clear of the same enable never meet. The bench drives every input on the falling edge and holds each pulse for one cycle. It performs one access per bus task, and it holds `eng_busy` steady across each command write, so every stimulus stays inside those limits. The corner cases are applied on purpose: the coincident pulse-and-acknowledge case, the coincident engine-load-and-bus-write case, and the command write while busy.

// File: rtl/flash_regs_pkg.sv
// Shared definitions for the flash controller register front end.
// Assumes a 32-bit data bus and word-aligned byte addresses.
package flash_regs_pkg;

    localparam int DATA_W = 32;

    // Word indices (byte offset / 4) of the mapped registers.
    localparam int IDX_RAW   = 'h20 / 4;
    localparam int IDX_MASKD = 'h24 / 4;
    localparam int IDX_ENSET = 'h28 / 4;
    localparam int IDX_ENCLR = 'h2C / 4;
    localparam int IDX_CLK   = 'h40 / 4;
    localparam int IDX_DEV   = 'h44 / 4;
    localparam int IDX_CMD   = 'h48 / 4;
    localparam int IDX_STAT  = 'h4C / 4;
    localparam int IDX_DATA  = 'h50 / 4;

    // Bit of the event registers that carries word completion.
    localparam int EVT_WORD = 1;

    // Writable bits of the clock word: enable in 31, divider in 15:0.
    localparam logic [DATA_W-1:0] CLK_KEEP = 32'h8000_FFFF;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_RAW,
        SEL_MASKD,
        SEL_ENSET,
        SEL_ENCLR,
        SEL_CLK,
        SEL_DEV,
        SEL_CMD,
        SEL_STAT,
        SEL_DATA
    } reg_sel_e;

endpackage

// File: rtl/flash_addr_decode.sv
// Address decoder: maps a byte address to one register selection.
// Assumes registers are word aligned; a non-aligned address or an
// unlisted word index selects nothing.
module flash_addr_decode
    import flash_regs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    assign widx = addr[ADDR_W-1:2];

    // Purpose: translate word index into register selection.
    always_comb begin
        sel = SEL_NONE;
        if (addr[1:0] == 2'b00) begin
            unique case (int'(widx))
                IDX_RAW:   sel = SEL_RAW;
                IDX_MASKD: sel = SEL_MASKD;
                IDX_ENSET: sel = SEL_ENSET;
                IDX_ENCLR: sel = SEL_ENCLR;
                IDX_CLK:   sel = SEL_CLK;
                IDX_DEV:   sel = SEL_DEV;
                IDX_CMD:   sel = SEL_CMD;
                IDX_STAT:  sel = SEL_STAT;
                IDX_DATA:  sel = SEL_DATA;
                default:   sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/flash_irq_ctrl.sv
// Interrupt controller: sticky pending bits, set/clear enable mask,
// write-one-to-acknowledge, and one level output.
// Assumes event inputs are single-cycle pulses and that the set and
// clear strobes never arrive together. IMPL_MASK names the live bits.
module flash_irq_ctrl #(
    parameter int               EVT_W     = 2,
    parameter logic [EVT_W-1:0] IMPL_MASK = 2'b10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_in,
    input  logic             en_set_we,
    input  logic             en_clr_we,
    input  logic             ack_we,
    input  logic [EVT_W-1:0] wbits,
    output logic [EVT_W-1:0] en_q,
    output logic [EVT_W-1:0] pend_q,
    output logic             irq
);

    for (genvar i = 0; i < EVT_W; i++) begin : g_bit
        if (IMPL_MASK[i]) begin : g_live
            // Purpose: enable bit changes only through set/clear strobes.
            always_ff @(posedge clk) begin
                if (!rst_n)                     en_q[i] <= 1'b0;
                else if (en_set_we && wbits[i]) en_q[i] <= 1'b1;
                else if (en_clr_we && wbits[i]) en_q[i] <= 1'b0;
            end

            // Purpose: pending bit; a new event beats an acknowledge.
            always_ff @(posedge clk) begin
                if (!rst_n)                  pend_q[i] <= 1'b0;
                else if (evt_in[i])          pend_q[i] <= 1'b1;
                else if (ack_we && wbits[i]) pend_q[i] <= 1'b0;
            end

            a_r4_event_pends: assert property (@(posedge clk) disable iff (!rst_n)
                evt_in[i] |=> pend_q[i]);
            a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
                (ack_we && wbits[i] && !evt_in[i]) |=> !pend_q[i]);
            a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
                (ack_we && wbits[i] && evt_in[i]) |=> pend_q[i]);
            a_r3_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
                (en_set_we && wbits[i]) |=> en_q[i]);
            a_r3_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
                (en_clr_we && wbits[i] && !en_set_we) |=> !en_q[i]);
        end else begin : g_dead
            assign en_q[i]   = 1'b0;
            assign pend_q[i] = 1'b0;
        end
    end

    assign irq = |(en_q & pend_q);

endmodule

// File: rtl/flash_cmd_gate.sv
// Command register: accepts a command only when the engine is idle and
// issues a one-cycle start strobe on the cycle after acceptance.
// Assumes eng_busy reflects the engine state at the write edge.
module flash_cmd_gate #(
    parameter int CMD_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             busy,
    input  logic [CMD_W-1:0] wdata,
    output logic [CMD_W-1:0] cmd_q,
    output logic             start_q
);

    logic accept;
    assign accept = we && !busy;

    // Purpose: hold the last accepted command word.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= '0;
        else if (accept) cmd_q <= wdata;
    end

    // Purpose: single-cycle start pulse following an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= accept;
    end

    a_r8_start_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> $past(we && !busy));
    a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (we && busy) |=> (!start_q && $stable(cmd_q)));

endmodule

// File: rtl/flash_ctl_regs.sv
// Register and interrupt front end of a serial flash controller.
// Decodes a 32-bit memory-mapped bus, holds configuration words for
// the transfer engine, gates command writes, and reports word
// completion as a level interrupt. Assumes one bus access per cycle
// and single-cycle engine pulses.
module flash_ctl_regs
    import flash_regs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              eng_busy,
    input  logic              eng_word_done,
    input  logic              eng_rx_load,
    input  logic [31:0]       eng_rx_data,
    output logic [31:0]       clk_cfg,
    output logic [31:0]       dev_cfg,
    output logic [31:0]       cmd_word,
    output logic              cmd_start,
    output logic [31:0]       tx_data,
    output logic              irq
);

    localparam int EVT_W = EVT_WORD + 1;
    localparam logic [EVT_W-1:0] EVT_LIVE = EVT_W'(1) << EVT_WORD;

    reg_sel_e         sel;
    logic             wr_en;
    logic             rd_en;
    logic [EVT_W-1:0] evt_vec;
    logic [EVT_W-1:0] en_mask;
    logic [EVT_W-1:0] pend;
    logic [31:0]      clk_q, dev_q, data_q;

    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && !bus_wr;

    flash_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign evt_vec = eng_word_done ? EVT_LIVE : '0;

    flash_irq_ctrl #(.EVT_W(EVT_W), .IMPL_MASK(EVT_LIVE)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_in    (evt_vec),
        .en_set_we (wr_en && sel == SEL_ENSET),
        .en_clr_we (wr_en && sel == SEL_ENCLR),
        .ack_we    (wr_en && sel == SEL_MASKD),
        .wbits     (bus_wdata[EVT_W-1:0]),
        .en_q      (en_mask),
        .pend_q    (pend),
        .irq       (irq)
    );

    flash_cmd_gate #(.CMD_W(32)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en && sel == SEL_CMD),
        .busy    (eng_busy),
        .wdata   (bus_wdata),
        .cmd_q   (cmd_word),
        .start_q (cmd_start)
    );

    // Purpose: clock and device configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q <= '0;
            dev_q <= '0;
        end else if (wr_en) begin
            if (sel == SEL_CLK) clk_q <= bus_wdata & CLK_KEEP;
            if (sel == SEL_DEV) dev_q <= bus_wdata;
        end
    end

    // Purpose: data word; an engine load takes precedence over the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)                          data_q <= '0;
        else if (eng_rx_load)                data_q <= eng_rx_data;
        else if (wr_en && sel == SEL_DATA)   data_q <= bus_wdata;
    end

    // Purpose: same-cycle read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_RAW:   bus_rdata = 32'(pend);
                SEL_MASKD: bus_rdata = 32'(pend & en_mask);
                SEL_ENSET: bus_rdata = 32'(en_mask);
                SEL_ENCLR: bus_rdata = 32'(en_mask);
                SEL_CLK:   bus_rdata = clk_q;
                SEL_DEV:   bus_rdata = dev_q;
                SEL_CMD:   bus_rdata = cmd_word;
                SEL_STAT:  bus_rdata = {30'd0, pend[EVT_WORD], eng_busy};
                SEL_DATA:  bus_rdata = data_q;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign clk_cfg = clk_q;
    assign dev_cfg = dev_q;
    assign tx_data = data_q;

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!irq && !cmd_start && clk_cfg == '0 && tx_data == '0));
    a_r2_clk_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_cfg & ~CLK_KEEP) == '0);
    a_r11_rx_load: assert property (@(posedge clk) disable iff (!rst_n)
        eng_rx_load |=> tx_data == $past(eng_rx_data));
    a_r10_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_NONE) |-> bus_rdata == '0);

endmodule

// File: tb/flash_ctl_regs_test.sv
`timescale 1ns/1ps
module flash_ctl_regs_test;

    localparam int AW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        eng_busy = 1'b0, eng_word_done = 1'b0, eng_rx_load = 1'b0;
    logic [31:0] eng_rx_data = '0;
    logic [31:0] clk_cfg, dev_cfg, cmd_word, tx_data;
    logic        cmd_start, irq;

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    // bench model of register contents
    logic [31:0] m_clk = 0, m_dev = 0, m_cmd = 0, m_data = 0;
    logic        m_en = 0, m_pend = 0;

    always #2 clk = ~clk;

    flash_ctl_regs #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_busy(eng_busy), .eng_word_done(eng_word_done),
        .eng_rx_load(eng_rx_load), .eng_rx_data(eng_rx_data),
        .clk_cfg(clk_cfg), .dev_cfg(dev_cfg), .cmd_word(cmd_word),
        .cmd_start(cmd_start), .tx_data(tx_data), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic logic [31:0] expect_at(input int off);
        case (off)
            'h20: return {30'd0, m_pend, 1'b0};
            'h24: return {30'd0, m_pend & m_en, 1'b0};
            'h28, 'h2C: return {30'd0, m_en, 1'b0};
            'h40: return m_clk;
            'h44: return m_dev;
            'h48: return m_cmd;
            'h4C: return {30'd0, m_pend, eng_busy};
            'h50: return m_data;
            default: return 32'd0;
        endcase
    endfunction

    function automatic bit mapped(input int off);
        return off inside {'h20, 'h24, 'h28, 'h2C, 'h40, 'h44, 'h48, 'h4C, 'h50};
    endfunction

    task automatic check_all(input string req);
        logic [31:0] v;
        for (int off = 0; off < 256; off += 4) begin
            if (mapped(off)) begin
                bus_read(AW'(off), v);
                check(req, v, expect_at(off));
            end
        end
        check(req, {31'd0, irq}, {31'd0, m_pend & m_en});
    endtask

    task automatic pulse_done();
        @(negedge clk); eng_word_done = 1'b1;
        @(negedge clk); eng_word_done = 1'b0;
        m_pend = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_all("R1");
        check("R1 cmd_start", {31'd0, cmd_start}, 32'd0);

        // R2: clock word keeps bit 31 and 15:0; device/data full width
        foreach (v[i]) begin end
        bus_write('h40, 32'hFFFF_FFFF); m_clk = 32'h8000_FFFF;
        check("R2 clk_cfg", clk_cfg, 32'h8000_FFFF);
        bus_write('h40, 32'h7FFF_1234); m_clk = 32'h0000_1234;
        bus_write('h44, 32'hA5C3_0F96); m_dev = 32'hA5C3_0F96;
        check("R2 dev_cfg", dev_cfg, 32'hA5C3_0F96);
        bus_write('h50, 32'h1357_9BDF); m_data = 32'h1357_9BDF;
        check("R2 tx_data", tx_data, 32'h1357_9BDF);
        check_all("R2");

        // R3: enable set/clear, zero in bit 1 has no effect
        bus_write('h28, 32'hFFFF_FFFD); check_all("R3 set with bit1=0");
        bus_write('h28, 32'h0000_0002); m_en = 1'b1; check_all("R3 set");
        bus_write('h2C, 32'hFFFF_FFFD); check_all("R3 clear with bit1=0");
        bus_write('h2C, 32'h0000_0002); m_en = 1'b0; check_all("R3 clear");

        // R4/R7: sweep enable x pending combinations
        for (int e = 0; e < 2; e++) begin
            for (int p = 0; p < 2; p++) begin
                if (e == 1) begin bus_write('h28, 2); m_en = 1; end
                else begin bus_write('h2C, 2); m_en = 0; end
                bus_write('h24, 2); m_pend = 0;
                if (p == 1) pulse_done();
                check_all("R4 R7 sweep");
            end
        end

        // R5: acknowledge semantics
        pulse_done();
        bus_write('h24, 32'hFFFF_FFFD); check_all("R5 ack bit1=0 keeps");
        bus_write('h20, 32'hFFFF_FFFF); check_all("R5 raw write ignored");
        bus_write('h24, 32'h0000_0002); m_pend = 0; check_all("R5 ack clears");

        // R6: pulse coincident with acknowledge stays pending
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 'h24; bus_wdata = 2; eng_word_done = 1;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; eng_word_done = 0;
        m_pend = 1;
        check_all("R6 event beats ack");
        bus_write('h24, 2); m_pend = 0;

        // R8: accepted command and single-cycle strobe
        for (int k = 0; k < 4; k++) begin
            logic [31:0] c;
            c = 32'h1000_0001 * (k + 3);
            bus_write('h48, c); m_cmd = c;
            check("R8 strobe high", {31'd0, cmd_start}, 32'd1);
            check("R8 cmd_word", cmd_word, c);
            @(negedge clk);
            check("R8 strobe one cycle", {31'd0, cmd_start}, 32'd0);
        end
        check_all("R8");

        // R9: busy blocks command writes
        eng_busy = 1'b1;
        bus_write('h48, 32'hDEAD_BEEF);
        check("R9 no strobe", {31'd0, cmd_start}, 32'd0);
        check("R9 cmd held", cmd_word, m_cmd);
        check_all("R9 busy");
        eng_busy = 1'b0;

        // R10: unmapped and misaligned offsets
        for (int a = 0; a < 256; a++) begin
            if (!(a[1:0] == 2'b00 && mapped(a))) begin
                bus_write(AW'(a), 32'hFFFF_FFFF);
                bus_read(AW'(a), v);
                check("R10 unmapped reads zero", v, 32'd0);
            end
        end
        check_all("R10 no side effect");
        check("R10 no strobe", {31'd0, cmd_start}, 32'd0);

        // R11: engine load, and priority over bus write
        @(negedge clk); eng_rx_load = 1; eng_rx_data = 32'hCAFE_0011;
        @(negedge clk); eng_rx_load = 0; m_data = 32'hCAFE_0011;
        check("R11 rx load", tx_data, 32'hCAFE_0011);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 'h50; bus_wdata = 32'h0BAD_0BAD;
        eng_rx_load = 1; eng_rx_data = 32'h600D_F00D;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; eng_rx_load = 0; m_data = 32'h600D_F00D;
        check_all("R11 engine wins");

        // R1: reset again clears everything
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        m_clk = 0; m_dev = 0; m_cmd = 0; m_data = 0; m_en = 0; m_pend = 0;
        check_all("R1 re-reset");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule